// File: doc/BRIEF.md
# Transmit Cell Header Check Byte Inserter

This block sits in the transmit path of a cell-based line interface. It takes 53-byte cells as a stream of bytes, with a flag that marks the first byte of each cell. It returns the same stream one clock later. The fifth byte of each cell is the header check slot. Depending on a mode input, that slot gets one of three values:
- a freshly computed CRC-8 over the four header bytes;
- the byte the host supplied, left untouched;
- a deliberately wrong check value, for exercising error counters further down the line.

Every other byte is forwarded unchanged. The output handshake matches the input handshake, so the block drops in between the cell source and the scrambler without any adapter. The block samples the mode on the first byte of each cell and holds it for the whole cell. A mode change while a cell is in flight therefore never splits that cell.

Top module: `hec_tx_inserter`

## Requirements
- R1: After reset, and until the first byte is accepted, `out_valid` is 0.
- R2: A byte accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high after exactly that edge. `out_soc` equals the `in_soc` that came with the byte.
- R3: `in_ready` is high whenever `out_ready` is high or the output holds no byte. While `out_valid` is high and `out_ready` is low, `out_data` and `out_soc` hold steady.
- R4: Mode code 0 (insert) replaces byte index 4 (the fifth byte; the first byte has index 0) with the following value. Take the CRC-8 of bytes 0 to 3 with generator x^8+x^2+x+1, remainder preset to 0, each byte fed most significant bit first. Then XOR the result with 0x55.
- R5: In mode code 1 (pass), the whole cell leaves unchanged, including byte index 4.
- R6: In mode code 2 (corrupt), byte index 4 equals the R4 value with bit 0 inverted.
- R7: Mode code 3 behaves exactly like mode code 1.
- R8: The mode is taken from the byte flagged with `in_soc`. Changes to `mode` on later bytes of the same cell have no effect on that cell.
- R9: Every byte other than index 4 of a cell is forwarded unchanged in all modes. This includes bytes that arrive outside a cell: before any `in_soc`, or after the last byte of a cell (index CELL_BYTES-1) and before the next `in_soc`.
- R10: An `in_soc` arriving in the middle of a cell starts a new cell at index 0. The check value of the new cell depends only on the new cell's own header bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Check byte mode: 0 insert, 1 pass, 2 corrupt, 3 pass |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input byte |
| in_soc | input | 1 | Input byte is the first byte of a cell |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | Output byte is the first byte of a cell |

## Verification
The bench builds the block with CELL_BYTES set to 8 and the header length left at 4. The check slot and the end-of-cell return to idle are then only a few bytes apart, so many hundreds of short cells fit in a short run.

Short cells make it possible to sweep every mode code against every walking-one header pattern and a spread of mixed headers. The expected check byte comes from a long division the bench performs on the 40-bit header-plus-zero word. The short cell also brings the out-of-cell bytes, a restart in mid-cell, a mode change in mid-cell and output stalls within a handful of cycles of each other.

// File: rtl/hec_tx_pkg.sv
package hec_tx_pkg;

  typedef enum logic [1:0] {
    HEC_INSERT   = 2'd0,
    HEC_PASS     = 2'd1,
    HEC_CORRUPT  = 2'd2,
    HEC_PASS_ALT = 2'd3
  } hec_mode_e;

  localparam logic [7:0] CRC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam logic [7:0] BAD_MASK  = 8'h01;

  // One byte of CRC-8 update, most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] r;
    r = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  // Value placed in the check slot for a given mode.
  function automatic logic [7:0] slot_value(input hec_mode_e m, input logic [7:0] hec,
                                            input logic [7:0] host_byte);
    logic [7:0] v;
    case (m)
      HEC_INSERT:  v = hec;
      HEC_CORRUPT: v = hec ^ BAD_MASK;
      default:     v = host_byte;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/hec_cell_tracker.sv
module hec_cell_tracker #(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic soc,
  output logic in_cell,
  output logic first_byte,
  output logic hdr_slot,
  output logic hec_slot
);
  localparam int CNT_W = $clog2(CELL_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_BYTES - 1);
  localparam logic [CNT_W-1:0] HEC_IDX  = CNT_W'(HDR_BYTES);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_idx;

  assign in_cell    = soc | active_q;
  assign cur_idx    = soc ? '0 : cnt_q;
  assign first_byte = soc;
  assign hdr_slot   = in_cell && (cur_idx < HEC_IDX);
  assign hec_slot   = in_cell && (cur_idx == HEC_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (beat && in_cell) begin
      if (cur_idx == LAST_IDX) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        active_q <= 1'b1;
        cnt_q    <= cur_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hec_crc_engine.sv
module hec_crc_engine
  import hec_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       hdr_slot,
  input  logic       first_byte,
  input  logic [7:0] data,
  output logic [7:0] hec_value
);
  logic [7:0] crc_q;
  logic [7:0] crc_base;

  assign crc_base  = first_byte ? 8'h00 : crc_q;
  assign hec_value = crc_q ^ HEC_COSET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 8'h00;
    end else if (beat && hdr_slot) begin
      crc_q <= crc8_step(crc_base, data);
    end
  end
endmodule

// File: rtl/hec_mode_hold.sv
module hec_mode_hold
  import hec_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      beat,
  input  logic      soc,
  input  hec_mode_e mode_i,
  output hec_mode_e cell_mode
);
  hec_mode_e mode_q;

  assign cell_mode = soc ? mode_i : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= HEC_INSERT;
    end else if (beat && soc) begin
      mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/hec_tx_inserter.sv
module hec_tx_inserter
  import hec_tx_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_soc,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_soc
);
  // Named internal events, visible to the bound checker.
  logic       beat;
  logic       in_cell;
  logic       first_byte;
  logic       hdr_slot;
  logic       hec_slot;
  logic [7:0] hec_value;
  hec_mode_e  cell_mode;
  logic [7:0] next_byte;

  assign in_ready = out_ready || !out_valid;
  assign beat     = in_valid && in_ready;

  hec_cell_tracker #(
    .CELL_BYTES(CELL_BYTES),
    .HDR_BYTES (HDR_BYTES)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .soc       (in_soc),
    .in_cell   (in_cell),
    .first_byte(first_byte),
    .hdr_slot  (hdr_slot),
    .hec_slot  (hec_slot)
  );

  hec_crc_engine u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .hdr_slot  (hdr_slot),
    .first_byte(first_byte),
    .data      (in_data),
    .hec_value (hec_value)
  );

  hec_mode_hold u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .soc      (in_soc),
    .mode_i   (hec_mode_e'(mode)),
    .cell_mode(cell_mode)
  );

  assign next_byte = hec_slot ? slot_value(cell_mode, hec_value, in_data) : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_soc   <= 1'b0;
    end else if (beat) begin
      out_valid <= 1'b1;
      out_data  <= next_byte;
      out_soc   <= in_soc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hec_tx_inserter_chk.sv
module hec_tx_inserter_chk
  import hec_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_soc,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_soc,
  input logic       hec_slot,
  input logic [7:0] hec_value,
  input logic [1:0] cell_mode
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && (out_soc == $past(in_soc))); // R2
  AST_NO_UPSTREAM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R3
  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_soc)); // R3
  AST_INSERT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hec_slot && cell_mode == 2'd0) |=> out_data == $past(hec_value)); // R4
  AST_PASS_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hec_slot && cell_mode[0]) |=> out_data == $past(in_data)); // R5
  AST_CORRUPT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hec_slot && cell_mode == 2'd2) |=> out_data == ($past(hec_value) ^ 8'h01)); // R6
  AST_DATA_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hec_slot) |=> out_data == $past(in_data)); // R9
endmodule

bind hec_tx_inserter hec_tx_inserter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .in_soc   (in_soc),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_soc  (out_soc),
  .hec_slot (hec_slot),
  .hec_value(hec_value),
  .cell_mode(cell_mode)
);

// File: tb/hec_tx_inserter_tb_top.sv
module hec_tx_inserter_tb_top;
  localparam int CB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_soc = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_soc;

  int checks = 0;
  int failures = 0;
  logic       pend_v = 1'b0;
  logic [7:0] pend_d = 8'h00;
  logic       pend_soc = 1'b0;
  string      pend_tag = "";
  logic       prev_ordy = 1'b1;

  always #5 clk = ~clk;

  hec_tx_inserter #(.CELL_BYTES(CB), .HDR_BYTES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_soc(in_soc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_soc(out_soc)
  );

  // Header check by long division of {header, 8'h00} by 0x107, then coset.
  function automatic logic [7:0] ref_hec(input logic [31:0] hdr);
    logic [39:0] w;
    w = {hdr, 8'h00};
    for (int b = 39; b >= 8; b--) begin
      if (w[b]) w[b -: 9] = w[b -: 9] ^ 9'h107;
    end
    return w[7:0] ^ 8'h55;
  endfunction

  function automatic logic [7:0] ref_slot(input logic [1:0] m, input logic [31:0] hdr,
                                          input logic [7:0] udf);
    if (m == 2'd0) return ref_hec(hdr);
    if (m == 2'd2) return {ref_hec(hdr)[7:1], ~ref_hec(hdr)[0]};
    return udf;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [7:0] id, input logic isoc,
                      input logic [1:0] im, input logic ordy, input logic [7:0] exp_d,
                      input string tag);
    @(negedge clk);
    if (pend_v && prev_ordy) begin
      check(pend_tag, out_valid && out_data == pend_d && out_soc == pend_soc,
            {7'd0, out_valid, out_data}, {8'd1, pend_d});
      check("R2", out_soc == pend_soc, {15'd0, out_soc}, {15'd0, pend_soc});
      pend_v = 1'b0;
    end
    in_valid = iv; in_data = id; in_soc = isoc; mode = im; out_ready = ordy;
    #1;
    if (iv && in_ready) begin
      pend_v = 1'b1; pend_d = exp_d; pend_soc = isoc; pend_tag = tag;
    end
    prev_ordy = ordy;
  endtask

  // Send one cell; from byte chg_at on, the mode input shows m2 (R8).
  task automatic send_cell(input logic [1:0] m, input logic [31:0] hdr,
                           input logic [7:0] udf, input logic [7:0] seed,
                           input int chg_at, input logic [1:0] m2);
    for (int b = 0; b < CB; b++) begin
      logic [7:0] d;
      logic [7:0] e;
      logic [1:0] mm;
      string t;
      d = (b < 4) ? hdr[31 - 8*b -: 8] : (b == 4) ? udf : 8'(seed + 8'(b * 13));
      e = (b == 4) ? ref_slot(m, hdr, udf) : d;
      mm = (chg_at >= 0 && b >= chg_at) ? m2 : m;
      if (chg_at >= 0) t = "R8";
      else if (b != 4) t = "R9";
      else if (m == 2'd0) t = "R4";
      else if (m == 2'd1) t = "R5";
      else if (m == 2'd2) t = "R6";
      else t = "R7";
      step(1'b1, d, b == 0, mm, 1'b1, e, t);
    end
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 8'h00, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", out_valid == 1'b0, {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid == 1'b0, {15'd0, out_valid}, 16'd0);

    // R9: bytes before any start of cell pass untouched, index 4 included.
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'hA0 + i), 1'b0, 2'd0, 1'b1, 8'(8'hA0 + i), "R9");
    idle();

    // All-zero header gives 0x55 (R4).
    send_cell(2'd0, 32'h0, 8'hEE, 8'h11, -1, 2'd0);

    // Sweep: every mode against walking-one and mixed headers.
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 32; k++)
        send_cell(2'(m), 32'h1 << k, 8'(k * 7 + 3), 8'(k), -1, 2'd0);
      for (int k = 0; k < 40; k++)
        send_cell(2'(m), 32'(k) * 32'h9E3779B1 + 32'h1234, 8'(k * 29), 8'(k + 50), -1, 2'd0);
    end

    // R9: bytes after a cell's end and before the next start pass untouched.
    send_cell(2'd0, 32'hDEADBEEF, 8'h00, 8'h40, -1, 2'd0);
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h30 + i), 1'b0, 2'd0, 1'b1, 8'(8'h30 + i), "R9");

    // R8: mode flips mid-cell, in both directions.
    send_cell(2'd0, 32'h01020304, 8'h77, 8'h10, 2, 2'd1);
    send_cell(2'd1, 32'h0A0B0C0D, 8'h66, 8'h20, 1, 2'd2);
    send_cell(2'd2, 32'hF0F0F0F0, 8'h55, 8'h30, 4, 2'd0);

    // R10: restart in mid-cell after three bytes of a broken cell.
    step(1'b1, 8'hFF, 1'b1, 2'd0, 1'b1, 8'hFF, "R10");
    step(1'b1, 8'hEE, 1'b0, 2'd0, 1'b1, 8'hEE, "R10");
    step(1'b1, 8'hDD, 1'b0, 2'd0, 1'b1, 8'hDD, "R10");
    send_cell(2'd0, 32'h00000001, 8'h99, 8'h60, -1, 2'd0);

    // R3: output stall holds data and blocks input, then drains.
    step(1'b1, 8'h5A, 1'b1, 2'd1, 1'b1, 8'h5A, "R3");
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 8'h11, 1'b0, 2'd1, 1'b0, 8'h11, "R3");
      check("R3", in_ready == 1'b0, {15'd0, in_ready}, 16'd0);
      check("R3", out_valid && out_data == 8'h5A, {7'd0, out_valid, out_data}, 16'h015A);
    end
    for (int b = 1; b < CB; b++) step(1'b1, 8'(b), 1'b0, 2'd1, 1'b1, 8'(b), "R3");
    idle();
    idle();
    check("R2", out_valid == 1'b0, {15'd0, out_valid}, 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule